// File: doc/BRIEF.md
# Dual-Channel Interleaved Sample Output Stage

This block is the digital output side of a two-channel converter. On every rising clock edge it captures one sample from channel A and one from channel B, both in offset-binary form. The pair travels through a fixed pipeline of `LATENCY` stages. It then leaves on one shared bus: channel A is driven while the clock is high and channel B while the clock is low. A channel flag tells the receiver which channel is on the bus at any moment.

A coding-select input picks offset binary or two's complement for the words that leave the pipeline. An active-low output enable releases the bus; its drive-enable output goes low and the data and flag lines are zeroed. A power-down input freezes the pipeline and holds the bus at the last word that was present before power-down. A sleep input also freezes the pipeline, so no new samples are accepted. After reset, power-down or sleep, a valid flag stays low until the pipeline holds only fresh samples.

Top module: `dual_ch_bus_out`

## Requirements
- R1: A channel A sample captured at rising edge k is on `bus_q` during the clock-high phase that follows rising edge k+`LATENCY` (default 5).
- R2: The channel B sample of the same pair is on `bus_q` during the clock-low phase that directly follows that high phase.
- R3: While the bus is driven and not held, `chan_flag` is 1 in the clock-high phase (channel A) and 0 in the clock-low phase (channel B).
- R4: `twos_sel`, sampled at the edge that loads a word into the output registers, selects the coding. Low passes offset binary unchanged. High inverts bit 9 (the MSB), which gives two's complement.
- R5: When `pwr_dn` is sampled high at a rising edge, the pipeline and output registers keep their contents. Until `pwr_dn` is sampled low again, `bus_q` shows the held channel B word in both clock phases and `chan_flag` is 0.
- R6: While `oe_n` is high, `drv_en` is 0 and `bus_q` and `chan_flag` are 0. While `oe_n` is low, `drv_en` is 1.
- R7: When `sleep` is sampled high at a rising edge, no sample is captured and the registers keep their contents. The bus keeps alternating between the frozen A and B words.
- R8: `out_valid` goes low after any edge at which `pwr_dn` or `sleep` is sampled high. It returns high at the `LATENCY`-th edge after the first edge at which both are sampled low; the same rule applies after reset.
- R9: While `rst_n` is low, all pipeline and output registers are 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; its level also selects the channel on the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_a | input | 10 | Channel A sample, offset binary |
| samp_b | input | 10 | Channel B sample, offset binary |
| twos_sel | input | 1 | 1 selects two's complement output coding |
| oe_n | input | 1 | Active-low output enable |
| pwr_dn | input | 1 | Power-down with output hold |
| sleep | input | 1 | Sleep: pipeline stops accepting samples |
| bus_q | output | 10 | Shared interleaved data bus |
| chan_flag | output | 1 | 1 while channel A is on the bus, 0 for channel B |
| drv_en | output | 1 | Drive enable for data and flag outputs |
| out_valid | output | 1 | High once the pipeline holds only fresh samples |

## Verification
The bench sends ramps that differ between the two channels, so a wrong latency or a swapped phase shows up as a word from the wrong position on the ramp. It switches the coding during the run and checks that only the MSB changes, and that the change appears at the output-load edge. Power-down and sleep are applied in the middle of the stream. A design that keeps shifting would show new words on the bus, and one that holds the wrong phase would show the A word or a flag of 1 during power-down. The bench also checks that the valid flag stays low for exactly `LATENCY` edges after each release, so a refill count that is off by one is caught.

// File: rtl/dual_out_pkg.sv
package dual_out_pkg;
    parameter int SAMP_W = 10;

    typedef logic [SAMP_W-1:0] samp_t;

    typedef struct packed {
        samp_t a;
        samp_t b;
    } pair_t;
endpackage

// File: rtl/sample_pipe.sv
module sample_pipe
    import dual_out_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    input  pair_t in_pair,
    output pair_t tail_pair
);
    for (genvar g = 0; g < LATENCY; g++) begin : g_st
        pair_t st_d;
        pair_t st_q;

        if (g == 0) begin : g_head
            always_comb begin
                st_d = st_q;
                if (advance) st_d = in_pair;
            end
        end else begin : g_body
            always_comb begin
                st_d = st_q;
                if (advance) st_d = g_st[g-1].st_q;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
    end

    assign tail_pair = g_st[LATENCY-1].st_q;

    // R1: a new pair enters the first stage on an advancing edge
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (g_st[0].st_q == $past(in_pair)));

    // R5 / R7: a halted edge freezes the pipeline tail
    a_r5_frozen_tail: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tail_pair));
endmodule

// File: rtl/out_coder.sv
module out_coder
    import dual_out_pkg::*;
(
    input  pair_t raw_pair,
    input  logic  twos_sel,
    output pair_t coded_pair
);
    localparam int MSB = SAMP_W - 1;

    always_comb begin
        coded_pair = raw_pair;
        if (twos_sel) begin
            coded_pair.a[MSB] = ~raw_pair.a[MSB];
            coded_pair.b[MSB] = ~raw_pair.b[MSB];
        end
    end
endmodule

// File: rtl/bus_mux.sv
module bus_mux
    import dual_out_pkg::*;
(
    input  logic  clk,
    input  logic  oe_n,
    input  logic  hold,
    input  pair_t out_pair,
    output samp_t bus_q,
    output logic  chan_flag,
    output logic  drv_en
);
    always_comb begin
        drv_en    = !oe_n;
        bus_q     = '0;
        chan_flag = 1'b0;
        if (!oe_n) begin
            if (hold) begin
                bus_q = out_pair.b;
            end else if (clk) begin
                bus_q     = out_pair.a;
                chan_flag = 1'b1;
            end else begin
                bus_q = out_pair.b;
            end
        end
    end

    // R6: a released bus carries nothing
    always_comb begin
        if (!drv_en) begin
            a_r6_quiet_bus: assert (bus_q == '0 && chan_flag == 1'b0);
        end
    end
endmodule

// File: rtl/dual_ch_bus_out.sv
module dual_ch_bus_out
    import dual_out_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  samp_a,
    input  logic [9:0]  samp_b,
    input  logic        twos_sel,
    input  logic        oe_n,
    input  logic        pwr_dn,
    input  logic        sleep,
    output logic [9:0]  bus_q,
    output logic        chan_flag,
    output logic        drv_en,
    output logic        out_valid
);
    localparam int FILL_MAX = LATENCY + 1;
    localparam int FILL_W   = $clog2(FILL_MAX + 1);
    localparam int MSB      = SAMP_W - 1;

    typedef struct packed {
        pair_t             out;
        logic              pd;
        logic [FILL_W-1:0] fill;
    } top_state_t;

    top_state_t st_d, st_q;
    pair_t      in_pair, tail_pair, coded_pair;
    logic       halt;
    samp_t      bus_w;

    assign halt      = pwr_dn || sleep;
    assign in_pair.a = samp_a;
    assign in_pair.b = samp_b;

    sample_pipe #(.LATENCY(LATENCY)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (!halt),
        .in_pair   (in_pair),
        .tail_pair (tail_pair)
    );

    out_coder u_coder (
        .raw_pair   (tail_pair),
        .twos_sel   (twos_sel),
        .coded_pair (coded_pair)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pd = pwr_dn;
        if (halt) begin
            st_d.fill = '0;
        end else begin
            st_d.out = coded_pair;
            if (st_q.fill != FILL_W'(FILL_MAX)) st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bus_mux u_mux (
        .clk       (clk),
        .oe_n      (oe_n),
        .hold      (st_q.pd),
        .out_pair  (st_q.out),
        .bus_q     (bus_w),
        .chan_flag (chan_flag),
        .drv_en    (drv_en)
    );

    assign bus_q     = bus_w;
    assign out_valid = (st_q.fill == FILL_W'(FILL_MAX));

    // R8: any halted edge drops the valid flag
    a_r8_halt_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !out_valid);

    // R8: valid only rises after an edge with no halt
    a_r8_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !$past(halt));

    // R4: output MSB follows the tail MSB xor the coding select
    a_r4_coding: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> (st_q.out.a[MSB] == ($past(tail_pair.a[MSB]) ^ $past(twos_sel))));
endmodule

// File: tb/dual_ch_bus_out_test.sv
module dual_ch_bus_out_test;
    localparam int LAT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] samp_a = '0, samp_b = '0;
    logic       twos_sel = 1'b0, oe_n = 1'b0, pwr_dn = 1'b0, sleep = 1'b0;
    logic [9:0] bus_q;
    logic       chan_flag, drv_en, out_valid;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_ch_bus_out #(.LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .samp_a(samp_a), .samp_b(samp_b),
        .twos_sel(twos_sel), .oe_n(oe_n), .pwr_dn(pwr_dn), .sleep(sleep),
        .bus_q(bus_q), .chan_flag(chan_flag), .drv_en(drv_en), .out_valid(out_valid)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // behavioural reference
    int  qa[$], qb[$];
    int  ea = 0, eb = 0, cnt = 0;
    bit  pdm = 0, slm = 0, twm = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            qa = {}; qb = {};
            for (int i = 0; i < LAT; i++) begin qa.push_back(0); qb.push_back(0); end
            ea = 0; eb = 0; cnt = 0; pdm = 0; slm = 0; twm = 0;
        end else begin
            pdm = pwr_dn;
            slm = sleep;
            if (pwr_dn || sleep) begin
                cnt = 0;
            end else begin
                int ta, tb;
                ta = qa.pop_front();
                tb = qb.pop_front();
                twm = twos_sel;
                ea = twos_sel ? (ta ^ 512) : ta;
                eb = twos_sel ? (tb ^ 512) : tb;
                qa.push_back(int'(samp_a));
                qb.push_back(int'(samp_b));
                if (cnt < LAT + 1) cnt++;
            end
        end
        #3;
        if (!done) begin
            if (oe_n) begin
                chk("R6 bus released (high)", bus_q, 0);
                chk("R6 flag released", chan_flag, 0);
                chk("R6 drive enable", drv_en, 0);
            end else if (pdm) begin
                chk("R5 held word (high)", bus_q, eb);
                chk("R5 held flag (high)", chan_flag, 0);
            end else begin
                chk(slm ? "R7 frozen A" : (twm ? "R4 coded A" : "R1 A word"), bus_q, ea);
                chk("R3 flag high phase", chan_flag, 1);
                chk("R6 drive enabled", drv_en, 1);
            end
            chk("R8 valid (high)", out_valid, (cnt == LAT + 1) ? 1 : 0);
        end
        #5;
        if (!done) begin
            if (oe_n) begin
                chk("R6 bus released (low)", bus_q, 0);
            end else if (pdm) begin
                chk("R5 held word (low)", bus_q, eb);
                chk("R5 held flag (low)", chan_flag, 0);
            end else begin
                chk(slm ? "R7 frozen B" : (twm ? "R4 coded B" : "R2 B word"), bus_q, eb);
                chk("R3 flag low phase", chan_flag, 0);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            samp_a = samp_a + 10'd7;
            samp_b = samp_b - 10'd5;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        samp_a = 10'd3;
        samp_b = 10'd1000;
        repeat (3) @(posedge clk);
        #2;
        chk("R9 reset valid", out_valid, 0);
        chk("R9 reset bus", bus_q, 0);
        rst_n = 1'b1;
        step(20);
        twos_sel = 1'b1;
        step(10);
        pwr_dn = 1'b1;
        step(4);
        pwr_dn = 1'b0;
        step(8);
        twos_sel = 1'b0;
        sleep = 1'b1;
        step(4);
        sleep = 1'b0;
        step(7);
        oe_n = 1'b1;
        step(3);
        oe_n = 1'b0;
        step(10);
        @(posedge clk);
        #9;
        finish_run();
    end

    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end
endmodule